// File: doc/BRIEF.md
# Temperature Alarm Event Controller

This block watches a stream of signed temperature samples and decides when a thermal event pin should be raised. Three trip thresholds are held locally: an upper and a lower bound that form an alarm window, and a critical level above the window. Every time a new sample is strobed in, the block updates three status flags. The flags report at-or-above critical, above the window and below the window, and each one uses a programmable hysteresis on its return path. The flags are meant to be returned with the temperature reading.

The event pin can follow the flags directly (comparator behaviour), latch on any window crossing until software clears it (interrupt behaviour), or respond to the critical level alone. A critical condition always drives the event and cannot be cleared by software. The pin's active level is selectable, and an enable holds the pin inactive without stopping the status logic. Two lock inputs freeze the critical register and the window registers against further writes.

Samples are 13-bit two's complement with a weight of 1/16 °C per LSB, so 0x19C stands for 25.75 °C. Trip values sit in a 16-bit register image at bits 12:2, with bit 2 worth 0.25 °C.

Top module: `thermal_event_ctrl`

## Requirements
- R1: A trip write stores wr_data[12:2] as an 11-bit signed value worth 0.25 °C per LSB. The readback shows that value at bits 12:2, with bits 15:13 and 1:0 reading as zero. All three trip registers reset to zero.
- R2: While cfg_lock_crit is 1, writes to the critical trip register are ignored.
- R3: While cfg_lock_win is 1, writes to the upper and lower trip registers are ignored.
- R4: The critical flag sets on a sample T >= Crit. Once set, it clears only on a sample T < Crit - H.
- R5: The above flag sets on a sample T > Upper. Once set, it clears only on a sample T <= Upper - H.
- R6: The below flag sets on a sample T < Lower - H. Once set, it clears on a sample T >= Lower.
- R7: H is chosen by cfg_hyst as 0 → 0 °C, 1 → 1.5 °C, 2 → 3 °C and 3 → 6 °C. The flags change only in the cycle after a sample_valid strobe, and are otherwise held.
- R8: With cfg_int_mode=0 and cfg_crit_only=0, event_stat equals crit | above | below.
- R9: With cfg_int_mode=1 and cfg_crit_only=0, a latch sets on any sample that changes the above or below flag, and holds until a sw_clear pulse. If a set and a clear arrive in the same cycle, the set wins. In this mode event_stat = latch | crit, so sw_clear never removes a critical event.
- R10: With cfg_crit_only=1, event_stat equals the critical flag in either mode.
- R11: When cfg_out_en=1 and event_stat=1, event_pin equals cfg_act_high. Otherwise event_pin equals the inverse of cfg_act_high. The flags and event_stat keep updating while the output is disabled.
- R12: After reset, all flags, the latch and event_stat are 0 and event_pin is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | Strobe: samp_temp holds a new reading |
| samp_temp | input | 13 | Signed temperature, 1/16 °C per LSB |
| wr_data | input | 16 | Trip register write image, value in bits 12:2 |
| wr_upper | input | 1 | Write strobe, upper trip |
| wr_lower | input | 1 | Write strobe, lower trip |
| wr_crit | input | 1 | Write strobe, critical trip |
| cfg_int_mode | input | 1 | 1 = latched interrupt behaviour, 0 = comparator |
| cfg_act_high | input | 1 | 1 = event pin active high, 0 = active low |
| cfg_crit_only | input | 1 | Event follows the critical flag only |
| cfg_out_en | input | 1 | Event pin enable |
| cfg_hyst | input | 2 | Hysteresis select |
| cfg_lock_win | input | 1 | Freeze upper and lower trip registers |
| cfg_lock_crit | input | 1 | Freeze critical trip register |
| sw_clear | input | 1 | Software clear of the interrupt latch |
| rd_upper | output | 16 | Upper trip readback |
| rd_lower | output | 16 | Lower trip readback |
| rd_crit | output | 16 | Critical trip readback |
| event_pin | output | 1 | Event output at the selected polarity |
| event_stat | output | 1 | Event status, independent of enable and polarity |
| flag_crit | output | 1 | Sample at or above critical |
| flag_above | output | 1 | Sample above the alarm window |
| flag_below | output | 1 | Sample below the alarm window |

## Verification
A wrong flag or hysteresis state becomes visible on the flag ports in the cycle after the sample that should have moved it. Through the selected mode, event_stat and event_pin show the same error in that cycle. A stale interrupt latch appears on event_stat at the first compare after the crossing or the clear that should have changed it. A lock that fails to hold appears on the trip readback one cycle after the blocked write. It also appears later as a flag that fires at the wrong temperature. The bench ramps the temperature through every threshold with each hysteresis step, alternates modes, polarity and enable, and compares all outputs with a behavioural model on every clock.

// File: rtl/thermal_event_pkg.sv
package thermal_event_pkg;

  typedef struct packed {
    logic crit;
    logic above;
    logic below;
  } trip_flags_t;

  // hysteresis in 1/16 degree units: 0, 1.5, 3, 6 degrees
  function automatic logic [6:0] hyst_sixteenths(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd0;
      2'd1:    return 7'd24;
      2'd2:    return 7'd48;
      default: return 7'd96;
    endcase
  endfunction

endpackage

// File: rtl/trip_regfile.sv
module trip_regfile #(
  parameter int TEMP_W = 13,
  parameter int REG_W  = 16,
  localparam int TRIP_W = TEMP_W - 2,
  localparam int N_TRIP = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [REG_W-1:0]              wr_data,
  input  logic [N_TRIP-1:0]             wr_req,   // {crit, lower, upper}
  input  logic                          lock_win,
  input  logic                          lock_crit,
  output logic [N_TRIP-1:0][TRIP_W-1:0] trip_q,
  output logic [N_TRIP-1:0][REG_W-1:0]  trip_rd
);

  logic [N_TRIP-1:0] lock_vec;
  assign lock_vec = {lock_crit, lock_win, lock_win};

  for (genvar i = 0; i < N_TRIP; i++) begin : g_trip
    logic [TRIP_W-1:0] val_q;
    logic [TRIP_W-1:0] val_d;
    logic              wr_en;

    assign wr_en = wr_req[i] && !lock_vec[i];

    always_comb begin
      val_d = val_q;
      if (wr_en) val_d = wr_data[TEMP_W-1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign trip_q[i]  = val_q;
    assign trip_rd[i] = {{(REG_W-TEMP_W){1'b0}}, val_q, 2'b00};
  end

  a_r2_crit_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req[2] && lock_crit) |=> $stable(trip_q[2]));

  a_r3_win_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_win && (wr_req[0] || wr_req[1])) |=> ($stable(trip_q[0]) && $stable(trip_q[1])));

endmodule

// File: rtl/thresh_compare.sv
module thresh_compare
  import thermal_event_pkg::*;
#(
  parameter int TEMP_W = 13,
  localparam int TRIP_W = TEMP_W - 2,
  localparam int EXT_W  = TEMP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_temp,
  input  logic [TRIP_W-1:0] upper_trip,
  input  logic [TRIP_W-1:0] lower_trip,
  input  logic [TRIP_W-1:0] crit_trip,
  input  logic [1:0]        hyst_sel,
  output trip_flags_t       flags_q,
  output logic              win_cross
);

  logic signed [EXT_W-1:0] t_x, u_x, l_x, c_x, h_x;
  trip_flags_t             flags_d;

  assign t_x = $signed({{2{samp_temp[TEMP_W-1]}}, samp_temp});
  assign u_x = $signed({{2{upper_trip[TRIP_W-1]}}, upper_trip, 2'b00});
  assign l_x = $signed({{2{lower_trip[TRIP_W-1]}}, lower_trip, 2'b00});
  assign c_x = $signed({{2{crit_trip[TRIP_W-1]}}, crit_trip, 2'b00});
  assign h_x = $signed({{(EXT_W-7){1'b0}}, hyst_sixteenths(hyst_sel)});

  always_comb begin
    flags_d = flags_q;
    if (samp_valid) begin
      flags_d.crit  = flags_q.crit  ? (t_x >= c_x - h_x) : (t_x >= c_x);
      flags_d.above = flags_q.above ? (t_x >  u_x - h_x) : (t_x >  u_x);
      flags_d.below = flags_q.below ? (t_x <  l_x)       : (t_x <  l_x - h_x);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign win_cross = samp_valid &&
                     ((flags_d.above != flags_q.above) || (flags_d.below != flags_q.below));

  a_r4_crit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && (t_x >= c_x)) |=> flags_q.crit);

  a_r5_above_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && flags_q.above && (t_x > u_x - h_x)) |=> flags_q.above);

  a_r6_below_needs_margin: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && !flags_q.below && (t_x >= l_x - h_x)) |=> !flags_q.below);

  a_r7_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_valid |=> $stable(flags_q));

endmodule

// File: rtl/event_drive.sv
module event_drive
  import thermal_event_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  trip_flags_t flags_q,
  input  logic        win_cross,
  input  logic        int_mode,
  input  logic        crit_only,
  input  logic        act_high,
  input  logic        out_en,
  input  logic        sw_clear,
  output logic        event_stat,
  output logic        event_pin
);

  logic lat_q, lat_d, lat_set;

  assign lat_set = win_cross && int_mode && !crit_only;

  always_comb begin
    lat_d = lat_q;
    if (lat_set)       lat_d = 1'b1;
    else if (sw_clear) lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  always_comb begin
    if (crit_only)     event_stat = flags_q.crit;
    else if (int_mode) event_stat = lat_q | flags_q.crit;
    else               event_stat = flags_q.crit | flags_q.above | flags_q.below;
  end

  assign event_pin = (out_en && event_stat) ? act_high : !act_high;

  a_r9_crit_not_clearable: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.crit |-> event_stat);

  a_r9_clear_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !win_cross) |=> !lat_q);

  a_r11_disabled_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (event_pin == !act_high));

endmodule

// File: rtl/thermal_event_ctrl.sv
module thermal_event_ctrl
  import thermal_event_pkg::*;
#(
  parameter int TEMP_W = 13,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_temp,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              wr_upper,
  input  logic              wr_lower,
  input  logic              wr_crit,
  input  logic              cfg_int_mode,
  input  logic              cfg_act_high,
  input  logic              cfg_crit_only,
  input  logic              cfg_out_en,
  input  logic [1:0]        cfg_hyst,
  input  logic              cfg_lock_win,
  input  logic              cfg_lock_crit,
  input  logic              sw_clear,
  output logic [REG_W-1:0]  rd_upper,
  output logic [REG_W-1:0]  rd_lower,
  output logic [REG_W-1:0]  rd_crit,
  output logic              event_pin,
  output logic              event_stat,
  output logic              flag_crit,
  output logic              flag_above,
  output logic              flag_below
);

  localparam int TRIP_W = TEMP_W - 2;

  logic [2:0][TRIP_W-1:0] trip_q;
  logic [2:0][REG_W-1:0]  trip_rd;
  trip_flags_t            flags_q;
  logic                   win_cross;

  trip_regfile #(.TEMP_W(TEMP_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data   (wr_data),
    .wr_req    ({wr_crit, wr_lower, wr_upper}),
    .lock_win  (cfg_lock_win),
    .lock_crit (cfg_lock_crit),
    .trip_q    (trip_q),
    .trip_rd   (trip_rd)
  );

  thresh_compare #(.TEMP_W(TEMP_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_valid (samp_valid),
    .samp_temp  (samp_temp),
    .upper_trip (trip_q[0]),
    .lower_trip (trip_q[1]),
    .crit_trip  (trip_q[2]),
    .hyst_sel   (cfg_hyst),
    .flags_q    (flags_q),
    .win_cross  (win_cross)
  );

  event_drive u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_q    (flags_q),
    .win_cross  (win_cross),
    .int_mode   (cfg_int_mode),
    .crit_only  (cfg_crit_only),
    .act_high   (cfg_act_high),
    .out_en     (cfg_out_en),
    .sw_clear   (sw_clear),
    .event_stat (event_stat),
    .event_pin  (event_pin)
  );

  assign rd_upper   = trip_rd[0];
  assign rd_lower   = trip_rd[1];
  assign rd_crit    = trip_rd[2];
  assign flag_crit  = flags_q.crit;
  assign flag_above = flags_q.above;
  assign flag_below = flags_q.below;

  a_r10_crit_only_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_crit_only |-> (event_stat == flag_crit));

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upper[1:0] == 2'b00) && (rd_crit[REG_W-1:TEMP_W] == '0));

endmodule

// File: tb/sim_thermal_event_ctrl.sv
module sim_thermal_event_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic [12:0] samp_temp = '0;
  logic [15:0] wr_data = '0;
  logic        wr_upper = 1'b0, wr_lower = 1'b0, wr_crit = 1'b0;
  logic        cfg_int_mode = 1'b0, cfg_act_high = 1'b1, cfg_crit_only = 1'b0;
  logic        cfg_out_en = 1'b1;
  logic [1:0]  cfg_hyst = 2'd0;
  logic        cfg_lock_win = 1'b0, cfg_lock_crit = 1'b0, sw_clear = 1'b0;
  logic [15:0] rd_upper, rd_lower, rd_crit;
  logic        event_pin, event_stat, flag_crit, flag_above, flag_below;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  int  m_up = 0, m_lo = 0, m_cr = 0;   // quarter degrees
  bit  m_fc = 0, m_fa = 0, m_fb = 0, m_lat = 0;

  thermal_event_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
    .wr_data(wr_data), .wr_upper(wr_upper), .wr_lower(wr_lower), .wr_crit(wr_crit),
    .cfg_int_mode(cfg_int_mode), .cfg_act_high(cfg_act_high),
    .cfg_crit_only(cfg_crit_only), .cfg_out_en(cfg_out_en), .cfg_hyst(cfg_hyst),
    .cfg_lock_win(cfg_lock_win), .cfg_lock_crit(cfg_lock_crit), .sw_clear(sw_clear),
    .rd_upper(rd_upper), .rd_lower(rd_lower), .rd_crit(rd_crit),
    .event_pin(event_pin), .event_stat(event_stat), .flag_crit(flag_crit),
    .flag_above(flag_above), .flag_below(flag_below));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int hyst_of(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 24;
      2'd2: return 48;
      default: return 96;
    endcase
  endfunction

  function automatic int trip_of(input logic [15:0] d);
    int v = int'(d[12:2]);
    if (v >= 1024) v -= 2048;
    return v;
  endfunction

  function automatic logic [15:0] rb_of(input int q);
    return 16'((q & 2047) << 2);
  endfunction

  // model update on the same edge the design registers
  always @(posedge clk) begin
    if (!rst_n) begin
      m_up = 0; m_lo = 0; m_cr = 0; m_fc = 0; m_fa = 0; m_fb = 0; m_lat = 0;
    end else begin
      int t, h;
      bit nc, na, nb;
      t = int'(samp_temp);
      if (t >= 4096) t -= 8192;
      h = hyst_of(cfg_hyst);
      nc = m_fc; na = m_fa; nb = m_fb;
      if (samp_valid) begin
        nc = m_fc ? (t >= m_cr*4 - h) : (t >= m_cr*4);
        na = m_fa ? (t >  m_up*4 - h) : (t >  m_up*4);
        nb = m_fb ? (t <  m_lo*4)     : (t <  m_lo*4 - h);
      end
      if (samp_valid && cfg_int_mode && !cfg_crit_only && (na != m_fa || nb != m_fb))
        m_lat = 1;
      else if (sw_clear)
        m_lat = 0;
      m_fc = nc; m_fa = na; m_fb = nb;
      if (wr_upper && !cfg_lock_win)  m_up = trip_of(wr_data);
      if (wr_lower && !cfg_lock_win)  m_lo = trip_of(wr_data);
      if (wr_crit  && !cfg_lock_crit) m_cr = trip_of(wr_data);
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    begin
      bit es, ep;
      if (cfg_crit_only)     es = m_fc;
      else if (cfg_int_mode) es = m_lat | m_fc;
      else                   es = m_fc | m_fa | m_fb;
      ep = (cfg_out_en && es) ? cfg_act_high : !cfg_act_high;
      if (!rst_n) begin
        chk("R12 reset flags", {13'b0, flag_crit, flag_above, flag_below}, 16'h0);
        chk("R12 reset stat", {15'b0, event_stat}, 16'h0);
        chk("R12 reset pin", {15'b0, event_pin}, {15'b0, !cfg_act_high});
        chk("R1 R12 reset trips", rd_upper | rd_lower | rd_crit, 16'h0);
      end else begin
        chk("R1 R3 upper readback", rd_upper, rb_of(m_up));
        chk("R1 R3 lower readback", rd_lower, rb_of(m_lo));
        chk("R1 R2 crit readback", rd_crit, rb_of(m_cr));
        chk("R4 R7 crit flag", {15'b0, flag_crit}, {15'b0, m_fc});
        chk("R5 R7 above flag", {15'b0, flag_above}, {15'b0, m_fa});
        chk("R6 R7 below flag", {15'b0, flag_below}, {15'b0, m_fb});
        if (cfg_crit_only)
          chk("R10 crit-only status", {15'b0, event_stat}, {15'b0, es});
        else if (cfg_int_mode)
          chk("R9 interrupt status", {15'b0, event_stat}, {15'b0, es});
        else
          chk("R8 comparator status", {15'b0, event_stat}, {15'b0, es});
        chk("R11 event pin", {15'b0, event_pin}, {15'b0, ep});
      end
    end
  end

  task automatic sample(input int t);
    @(negedge clk);
    samp_temp  = 13'(t);
    samp_valid = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic wr_trip(input int which, input int q);
    @(negedge clk);
    wr_data = {3'b101, 11'(q), 2'b11};   // junk in the reserved bits
    wr_upper = (which == 0);
    wr_lower = (which == 1);
    wr_crit  = (which == 2);
    @(negedge clk);
    wr_upper = 1'b0; wr_lower = 1'b0; wr_crit = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
  endtask

  task automatic ramp(input int from, input int to, input int step);
    if (from <= to) for (int t = from; t <= to; t += step) sample(t);
    else            for (int t = from; t >= to; t -= step) sample(t);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: trips in quarter degrees: upper 85, lower 10, crit 95
    wr_trip(0, 340);
    wr_trip(1, 40);
    wr_trip(2, 380);

    // R8 comparator sweep with no hysteresis, R4 R5 R6 edges
    ramp(0, 1700, 50);
    sample(1520); sample(1519); sample(1361); sample(1360);
    sample(160); sample(159); sample(160);
    ramp(1700, -200, 70);

    // R7 samples without a strobe are ignored
    @(negedge clk); samp_temp = 13'd2000;
    repeat (4) @(negedge clk);

    // R7 every hysteresis step, fine ramps through all thresholds
    for (int h = 0; h < 4; h++) begin
      cfg_hyst = 2'(h);
      ramp(-100, 1650, 12);
      ramp(1650, -100, 8);
    end

    // R9 interrupt behaviour
    cfg_int_mode = 1'b1;
    cfg_hyst = 2'd1;
    ramp(400, 1400, 40);
    repeat (3) @(negedge clk);
    pulse_clear();
    ramp(1400, 1600, 20);
    pulse_clear();                       // crit stays
    sample(1600);
    ramp(1600, 100, 60);
    pulse_clear();
    ramp(100, 1380, 30);
    // set and clear in the same cycle
    @(negedge clk);
    samp_temp = 13'd300; samp_valid = 1'b1; sw_clear = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0; sw_clear = 1'b0;
    pulse_clear();

    // negative lower bound: -5 degrees
    wr_trip(1, -20);
    ramp(200, -200, 16);
    ramp(-200, 200, 16);

    // R10 critical-only in both modes
    cfg_crit_only = 1'b1;
    ramp(100, 1650, 50);
    pulse_clear();
    ramp(1650, 100, 50);
    cfg_int_mode = 1'b0;
    ramp(100, 1650, 75);
    ramp(1650, 100, 75);
    cfg_crit_only = 1'b0;

    // R11 polarity and enable
    cfg_act_high = 1'b0;
    ramp(0, 1600, 100);
    cfg_out_en = 1'b0;
    ramp(1600, -400, 100);
    cfg_act_high = 1'b1;
    ramp(-400, 1600, 100);
    cfg_out_en = 1'b1;
    ramp(1600, 0, 100);

    // R2 R3 locks
    cfg_lock_crit = 1'b1;
    wr_trip(2, 200);
    sample(880);                          // 55 degrees, below the held crit
    cfg_lock_win = 1'b1;
    wr_trip(0, 100);
    wr_trip(1, 0);
    sample(880);
    cfg_lock_crit = 1'b0; cfg_lock_win = 1'b0;
    wr_trip(2, 200);
    wr_trip(0, 100);
    sample(880);
    sample(500);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule